// File: doc/BRIEF.md
# Bank-Switched Register File

This block is a general-purpose register file that holds four complete banks of registers. Only one bank is active at a time: its two read ports and its write port serve the processor's normal operand traffic. When an interrupt or a system call is taken, the active bank changes in hardware. The handler therefore gets a fresh set of registers, and the interrupted context stays untouched without any save or restore by software.

A 2-bit bank-select field chooses the active bank. Its value is the bank number. Banks 0 and 1 hold user tasks, and software assigns them by loading the field. Bank 2 belongs to the kernel and the system-call handler. Bank 3 belongs to interrupt handling. An interrupt-entry or syscall-entry event saves the current bank number in a single-level shadow field. A return event loads the shadow back into the field.

A cross-bank port reads any register of any named bank and writes any register of any named bank. Together with the normal read and write ports, it moves values between the active bank and a bank that is not active.

Top module: `bsrf_top`

## Requirements
- R1: While reset is asserted and after it is released, every register of every bank reads as zero, and the bank-select field (`cur_bank`) holds 2, the kernel bank.
- R2: When `wr_en` is high at a clock edge, `wr_data` is stored in register `wr_addr` of the bank that is active in that cycle. A read of that register from the next cycle on returns the value, and registers of other banks keep their contents.
- R3: `irq_enter` at a clock edge makes bank 3 active from the next cycle and copies the previous bank number into the shadow field. It has priority over every other bank-select input.
- R4: `sys_enter` without `irq_enter` makes bank 2 active from the next cycle and copies the previous bank number into the shadow field.
- R5: `evt_return` without an entry event makes the shadow field's bank number active from the next cycle.
- R6: `sel_wr_en` loads `sel_wr_val` into the bank-select field at the clock edge only when no entry or return event is present. With no such input, the field keeps its value.
- R7: Register 0 of every bank reads as zero on all read ports. Writes to it through the active-bank port or the cross-bank port are ignored.
- R8: In the cycle in which a bank switch is requested, reads and the active-bank write use the old bank. Reads in the following cycle use the new bank.
- R9: A read on either active-bank port whose address matches a same-cycle active-bank write to a nonzero register returns the data being written, before the clock edge.
- R10: `xm_rdata` combinationally shows register `xm_addr` of bank `xm_bank`, whichever bank is active.
- R11: When `xm_wr_en` is high at a clock edge, `xm_wdata` is stored in register `xm_addr` of bank `xm_bank`. This bank may be the active one or any other.
- R12: When an active-bank write and a cross-bank write in the same cycle target the same bank and the same register, the active-bank write's data is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_a_addr | input | ADDR_W | Register address of read port A (active bank) |
| rd_a_data | output | DATA_W | Read data of port A |
| rd_b_addr | input | ADDR_W | Register address of read port B (active bank) |
| rd_b_data | output | DATA_W | Read data of port B |
| wr_en | input | 1 | Write enable of the active-bank write port |
| wr_addr | input | ADDR_W | Register address of the active-bank write |
| wr_data | input | DATA_W | Data of the active-bank write |
| sel_wr_en | input | 1 | Load the bank-select field from `sel_wr_val` |
| sel_wr_val | input | 2 | New bank number for the bank-select field |
| irq_enter | input | 1 | Interrupt-entry event |
| sys_enter | input | 1 | Syscall-entry event |
| evt_return | input | 1 | Return event, restores the shadowed bank number |
| cur_bank | output | 2 | Bank-select field, the number of the active bank |
| xm_bank | input | 2 | Bank number addressed by the cross-bank port |
| xm_addr | input | ADDR_W | Register address of the cross-bank port |
| xm_rdata | output | DATA_W | Cross-bank read data |
| xm_wr_en | input | 1 | Cross-bank write enable |
| xm_wdata | input | DATA_W | Cross-bank write data |

## Verification
A table of writes scattered over all four banks is replayed. The bank is first chosen through the select field, and the data is then read back both through the active ports and through the cross-bank port. This shows whether the bank and register indices are decoded independently, and whether register 0 is sealed in every bank. Directed sequences apply each event alone and in combination with the others, which separates the priority order and the shadow save and restore. Writes and reads issued in the very cycle of a switch tell apart the old-bank and new-bank timing. Same-cycle pairs of active and cross-bank writes, to equal and to distinct targets, distinguish the conflict rule from independent writes, and same-cycle reads and writes distinguish bypass from stale data.

// File: rtl/bsrf_pkg.sv
package bsrf_pkg;

   localparam int unsigned BANK_W    = 2;
   localparam int unsigned NUM_BANKS = 1 << BANK_W;

   typedef logic [BANK_W-1:0] bank_t;

   // Banks with a fixed role; banks 0 and 1 are handed out by software.
   localparam bank_t BANK_KERNEL = bank_t'(2);
   localparam bank_t BANK_IRQ    = bank_t'(3);

   typedef enum logic [2:0] {
      EV_HOLD,
      EV_LOAD,
      EV_IRQ,
      EV_SYS,
      EV_RET
   } bank_event_e;

   // Priority: interrupt entry, syscall entry, return, software load.
   function automatic bank_event_e pick_event(input logic irq,
                                              input logic sys,
                                              input logic ret,
                                              input logic load);
      if (irq)       return EV_IRQ;
      else if (sys)  return EV_SYS;
      else if (ret)  return EV_RET;
      else if (load) return EV_LOAD;
      else           return EV_HOLD;
   endfunction

endpackage

// File: rtl/bsrf_bank_ctrl.sv
module bsrf_bank_ctrl
   import bsrf_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  irq_i,
   input  logic  sys_i,
   input  logic  ret_i,
   input  logic  load_i,
   input  bank_t load_val_i,
   output bank_t bank_o,
   output bank_t shadow_o
);

   bank_t       bank_q, bank_d;
   bank_t       shadow_q, shadow_d;
   bank_event_e ev;

   always_comb begin
      ev       = pick_event(irq_i, sys_i, ret_i, load_i);
      bank_d   = bank_q;
      shadow_d = shadow_q;
      case (ev)
         EV_IRQ: begin
            shadow_d = bank_q;
            bank_d   = BANK_IRQ;
         end
         EV_SYS: begin
            shadow_d = bank_q;
            bank_d   = BANK_KERNEL;
         end
         EV_RET:  bank_d = shadow_q;
         EV_LOAD: bank_d = load_val_i;
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bank_q   <= BANK_KERNEL;
         shadow_q <= BANK_KERNEL;
      end else begin
         bank_q   <= bank_d;
         shadow_q <= shadow_d;
      end
   end

   assign bank_o   = bank_q;
   assign shadow_o = shadow_q;

endmodule

// File: rtl/bsrf_storage.sv
module bsrf_storage
   import bsrf_pkg::*;
#(
   parameter  int DATA_W   = 32,
   parameter  int NUM_REGS = 16,
   localparam int ADDR_W   = $clog2(NUM_REGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  bank_t             act_bank_i,
   input  logic              act_we_i,
   input  logic [ADDR_W-1:0] act_addr_i,
   input  logic [DATA_W-1:0] act_wdata_i,
   input  bank_t             x_bank_i,
   input  logic              x_we_i,
   input  logic [ADDR_W-1:0] x_addr_i,
   input  logic [DATA_W-1:0] x_wdata_i,
   output logic [DATA_W-1:0] regs_o [NUM_BANKS][NUM_REGS]
);

   for (genvar b = 0; b < int'(NUM_BANKS); b++) begin : g_bank
      for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
         if (r == 0) begin : g_zero
            assign regs_o[b][r] = '0;
         end else begin : g_live
            logic              act_hit;
            logic              x_hit;
            logic [DATA_W-1:0] q;

            assign act_hit = act_we_i && (act_bank_i == bank_t'(b))
                             && (act_addr_i == ADDR_W'(r));
            assign x_hit   = x_we_i && (x_bank_i == bank_t'(b))
                             && (x_addr_i == ADDR_W'(r));

            // Active-bank write is tested first and so wins a collision.
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)       q <= '0;
               else if (act_hit) q <= act_wdata_i;
               else if (x_hit)   q <= x_wdata_i;
            end

            assign regs_o[b][r] = q;
         end
      end
   end

endmodule

// File: rtl/bsrf_read_port.sv
module bsrf_read_port
   import bsrf_pkg::*;
#(
   parameter  int DATA_W   = 32,
   parameter  int NUM_REGS = 16,
   parameter  bit BYPASS   = 1'b1,
   localparam int ADDR_W   = $clog2(NUM_REGS)
) (
   input  bank_t             bank_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] regs_i [NUM_BANKS][NUM_REGS],
   input  logic              fwd_we_i,
   input  logic [ADDR_W-1:0] fwd_addr_i,
   input  logic [DATA_W-1:0] fwd_data_i,
   output logic [DATA_W-1:0] data_o
);

   logic [DATA_W-1:0] raw;

   assign raw = regs_i[bank_i][addr_i];

   if (BYPASS) begin : g_fwd
      logic hit;
      assign hit    = fwd_we_i && (fwd_addr_i == addr_i) && (addr_i != '0);
      assign data_o = hit ? fwd_data_i : raw;
   end else begin : g_plain
      logic unused_fwd;
      assign unused_fwd = fwd_we_i ^ (^fwd_addr_i) ^ (^fwd_data_i);
      assign data_o     = raw;
   end

endmodule

// File: rtl/bsrf_top.sv
module bsrf_top
   import bsrf_pkg::*;
#(
   parameter  int DATA_W   = 32,
   parameter  int NUM_REGS = 16,
   parameter  bit BYPASS   = 1'b1,
   localparam int ADDR_W   = $clog2(NUM_REGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] rd_a_addr,
   output logic [DATA_W-1:0] rd_a_data,
   input  logic [ADDR_W-1:0] rd_b_addr,
   output logic [DATA_W-1:0] rd_b_data,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              sel_wr_en,
   input  logic [1:0]        sel_wr_val,
   input  logic              irq_enter,
   input  logic              sys_enter,
   input  logic              evt_return,
   output logic [1:0]        cur_bank,
   input  logic [1:0]        xm_bank,
   input  logic [ADDR_W-1:0] xm_addr,
   output logic [DATA_W-1:0] xm_rdata,
   input  logic              xm_wr_en,
   input  logic [DATA_W-1:0] xm_wdata
);

   localparam int NUM_RD = 2;

   if (DATA_W < 1) begin : g_bad_width
      $error("bsrf_top: DATA_W must be at least 1");
   end
   if (NUM_REGS < 2 || (NUM_REGS & (NUM_REGS - 1)) != 0) begin : g_bad_depth
      $error("bsrf_top: NUM_REGS must be a power of two, at least 2");
   end

   bank_t             bank_q;
   bank_t             shadow_q;
   logic [DATA_W-1:0] regs [NUM_BANKS][NUM_REGS];
   logic [ADDR_W-1:0] rd_addr [NUM_RD];
   logic [DATA_W-1:0] rd_data [NUM_RD];

   bsrf_bank_ctrl i_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .irq_i      (irq_enter),
      .sys_i      (sys_enter),
      .ret_i      (evt_return),
      .load_i     (sel_wr_en),
      .load_val_i (sel_wr_val),
      .bank_o     (bank_q),
      .shadow_o   (shadow_q)
   );

   bsrf_storage #(
      .DATA_W   (DATA_W),
      .NUM_REGS (NUM_REGS)
   ) i_store (
      .clk         (clk),
      .rst_n       (rst_n),
      .act_bank_i  (bank_q),
      .act_we_i    (wr_en),
      .act_addr_i  (wr_addr),
      .act_wdata_i (wr_data),
      .x_bank_i    (xm_bank),
      .x_we_i      (xm_wr_en),
      .x_addr_i    (xm_addr),
      .x_wdata_i   (xm_wdata),
      .regs_o      (regs)
   );

   assign rd_addr[0] = rd_a_addr;
   assign rd_addr[1] = rd_b_addr;

   for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
      bsrf_read_port #(
         .DATA_W   (DATA_W),
         .NUM_REGS (NUM_REGS),
         .BYPASS   (BYPASS)
      ) i_port (
         .bank_i     (bank_q),
         .addr_i     (rd_addr[p]),
         .regs_i     (regs),
         .fwd_we_i   (wr_en),
         .fwd_addr_i (wr_addr),
         .fwd_data_i (wr_data),
         .data_o     (rd_data[p])
      );
   end

   assign rd_a_data = rd_data[0];
   assign rd_b_data = rd_data[1];
   assign xm_rdata  = regs[xm_bank][xm_addr];
   assign cur_bank  = bank_q;

endmodule

// File: rtl/bsrf_chk.sv
module bsrf_chk #(
   parameter  int DATA_W   = 32,
   parameter  int NUM_REGS = 16,
   parameter  bit BYPASS   = 1'b1,
   localparam int ADDR_W   = $clog2(NUM_REGS)
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] rd_a_addr,
   input logic [DATA_W-1:0] rd_a_data,
   input logic [ADDR_W-1:0] rd_b_addr,
   input logic [DATA_W-1:0] rd_b_data,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic              sel_wr_en,
   input logic              irq_enter,
   input logic              sys_enter,
   input logic              evt_return,
   input logic [1:0]        cur_bank,
   input logic [1:0]        shadow_q,
   input logic [ADDR_W-1:0] xm_addr,
   input logic [DATA_W-1:0] xm_rdata
);

   a_r3_irq_bank: assert property (@(posedge clk) disable iff (!rst_n)
      irq_enter |=> cur_bank == 2'd3);

   a_r3_irq_shadow: assert property (@(posedge clk) disable iff (!rst_n)
      irq_enter |=> shadow_q == $past(cur_bank));

   a_r4_sys_bank: assert property (@(posedge clk) disable iff (!rst_n)
      (sys_enter && !irq_enter) |=> cur_bank == 2'd2);

   a_r5_return: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_return && !irq_enter && !sys_enter) |=> cur_bank == $past(shadow_q));

   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_enter && !sys_enter && !evt_return && !sel_wr_en) |=> $stable(cur_bank));

   a_r7_zero_a: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_a_addr == '0) |-> (rd_a_data == '0));

   a_r7_zero_b: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_b_addr == '0) |-> (rd_b_data == '0));

   a_r7_zero_xm: assert property (@(posedge clk) disable iff (!rst_n)
      (xm_addr == '0) |-> (xm_rdata == '0));

   a_r9_bypass_a: assert property (@(posedge clk) disable iff (!rst_n)
      (BYPASS && wr_en && wr_addr != '0 && rd_a_addr == wr_addr) |-> rd_a_data == wr_data);

   a_r9_bypass_b: assert property (@(posedge clk) disable iff (!rst_n)
      (BYPASS && wr_en && wr_addr != '0 && rd_b_addr == wr_addr) |-> rd_b_data == wr_data);

endmodule

bind bsrf_top bsrf_chk #(
   .DATA_W   (DATA_W),
   .NUM_REGS (NUM_REGS),
   .BYPASS   (BYPASS)
) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .rd_a_addr  (rd_a_addr),
   .rd_a_data  (rd_a_data),
   .rd_b_addr  (rd_b_addr),
   .rd_b_data  (rd_b_data),
   .wr_en      (wr_en),
   .wr_addr    (wr_addr),
   .wr_data    (wr_data),
   .sel_wr_en  (sel_wr_en),
   .irq_enter  (irq_enter),
   .sys_enter  (sys_enter),
   .evt_return (evt_return),
   .cur_bank   (cur_bank),
   .shadow_q   (shadow_q),
   .xm_addr    (xm_addr),
   .xm_rdata   (xm_rdata)
);

// File: tb/test_bsrf_top.sv
module test_bsrf_top;

   localparam int CLK_PERIOD = 10;
   localparam int DATA_W     = 32;
   localparam int NUM_REGS   = 16;
   localparam int ADDR_W     = $clog2(NUM_REGS);
   localparam int WATCHDOG   = 20000;
   localparam int NVEC       = 8;

   // {bank[1:0], addr[3:0], data[31:0], expected read[31:0]}
   localparam logic [69:0] VEC [NVEC] = '{
      {2'd0, 4'd1,  32'h1111_0001, 32'h1111_0001},
      {2'd0, 4'd15, 32'hA5A5_A5A5, 32'hA5A5_A5A5},
      {2'd1, 4'd1,  32'h2222_0001, 32'h2222_0001},
      {2'd1, 4'd0,  32'hDEAD_BEEF, 32'h0000_0000},
      {2'd2, 4'd3,  32'h3333_0003, 32'h3333_0003},
      {2'd3, 4'd1,  32'h4444_0001, 32'h4444_0001},
      {2'd3, 4'd15, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
      {2'd2, 4'd8,  32'h0000_0080, 32'h0000_0080}
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [ADDR_W-1:0] rd_a_addr = '0;
   logic [DATA_W-1:0] rd_a_data;
   logic [ADDR_W-1:0] rd_b_addr = '0;
   logic [DATA_W-1:0] rd_b_data;
   logic              wr_en = 1'b0;
   logic [ADDR_W-1:0] wr_addr = '0;
   logic [DATA_W-1:0] wr_data = '0;
   logic              sel_wr_en = 1'b0;
   logic [1:0]        sel_wr_val = '0;
   logic              irq_enter = 1'b0;
   logic              sys_enter = 1'b0;
   logic              evt_return = 1'b0;
   logic [1:0]        cur_bank;
   logic [1:0]        xm_bank = '0;
   logic [ADDR_W-1:0] xm_addr = '0;
   logic [DATA_W-1:0] xm_rdata;
   logic              xm_wr_en = 1'b0;
   logic [DATA_W-1:0] xm_wdata = '0;

   int n_tests = 0;
   int n_fail  = 0;
   int cycles  = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   bsrf_top i_bsrf_top (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_a_addr  (rd_a_addr),
      .rd_a_data  (rd_a_data),
      .rd_b_addr  (rd_b_addr),
      .rd_b_data  (rd_b_data),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .sel_wr_en  (sel_wr_en),
      .sel_wr_val (sel_wr_val),
      .irq_enter  (irq_enter),
      .sys_enter  (sys_enter),
      .evt_return (evt_return),
      .cur_bank   (cur_bank),
      .xm_bank    (xm_bank),
      .xm_addr    (xm_addr),
      .xm_rdata   (xm_rdata),
      .xm_wr_en   (xm_wr_en),
      .xm_wdata   (xm_wdata)
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > WATCHDOG) begin
         n_fail = n_fail + 1;
         $display("FAIL watchdog: run exceeded %0d cycles", WATCHDOG);
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   task automatic check(input string tag, input logic [DATA_W-1:0] act,
                        input logic [DATA_W-1:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // Inputs change at the falling edge; outputs are sampled 1 time unit later.
   task automatic tick;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic set_bank(input logic [1:0] b);
      sel_wr_en  = 1'b1;
      sel_wr_val = b;
      tick();
      sel_wr_en  = 1'b0;
      #1;
      check("R6 software bank load", 32'(cur_bank), 32'(b));
   endtask

   task automatic write_act(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
      wr_en   = 1'b1;
      wr_addr = a;
      wr_data = d;
      tick();
      wr_en   = 1'b0;
   endtask

   task automatic pulse(input logic irq, input logic sys, input logic ret);
      irq_enter  = irq;
      sys_enter  = sys;
      evt_return = ret;
      tick();
      irq_enter  = 1'b0;
      sys_enter  = 1'b0;
      evt_return = 1'b0;
      #1;
   endtask

   initial begin
      // R1: reset state
      tick();
      #1;
      check("R1 bank during reset", 32'(cur_bank), 32'd2);
      rst_n = 1'b1;
      tick();
      #1;
      check("R1 bank after reset", 32'(cur_bank), 32'd2);
      xm_bank = 2'd0; xm_addr = 4'd1; #1;
      check("R1 bank0 reg1 cleared", xm_rdata, 32'h0);
      xm_bank = 2'd3; xm_addr = 4'd15; #1;
      check("R1 bank3 reg15 cleared", xm_rdata, 32'h0);

      // Table: write each entry into its bank through the active port (R2, R6)
      for (int i = 0; i < NVEC; i++) begin
         set_bank(VEC[i][69:68]);
         write_act(VEC[i][67:64], VEC[i][63:32]);
      end
      // Read back through the cross-bank port (R10) and the active port (R2, R7)
      for (int i = 0; i < NVEC; i++) begin
         xm_bank = VEC[i][69:68];
         xm_addr = VEC[i][67:64];
         #1;
         check("R10 cross-bank read of table entry", xm_rdata, VEC[i][31:0]);
         set_bank(VEC[i][69:68]);
         rd_a_addr = VEC[i][67:64];
         #1;
         check("R2 active read of table entry", rd_a_data, VEC[i][31:0]);
      end

      // R8: switch cycle uses the old bank for reads and writes
      set_bank(2'd0);
      irq_enter = 1'b1;
      wr_en = 1'b1; wr_addr = 4'd5; wr_data = 32'h0000_0055;
      rd_a_addr = 4'd5; rd_b_addr = 4'd1;
      #1;
      check("R8 read in switch cycle from old bank", rd_b_data, 32'h1111_0001);
      check("R9 bypass on port A", rd_a_data, 32'h0000_0055);
      tick();
      irq_enter = 1'b0; wr_en = 1'b0;
      #1;
      check("R3 interrupt entry selects bank 3", 32'(cur_bank), 32'd3);
      check("R8 read after switch from new bank", rd_b_data, 32'h4444_0001);
      xm_bank = 2'd0; xm_addr = 4'd5; #1;
      check("R8 switch-cycle write landed in old bank", xm_rdata, 32'h0000_0055);
      xm_bank = 2'd3; #1;
      check("R8 new bank untouched by switch-cycle write", xm_rdata, 32'h0);

      // R5: return restores the shadowed bank
      pulse(1'b0, 1'b0, 1'b1);
      check("R5 return to bank 0", 32'(cur_bank), 32'd0);

      // R4: syscall entry and return
      pulse(1'b0, 1'b1, 1'b0);
      check("R4 syscall entry selects bank 2", 32'(cur_bank), 32'd2);
      pulse(1'b0, 1'b0, 1'b1);
      check("R5 return from syscall to bank 0", 32'(cur_bank), 32'd0);

      // R3: interrupt outranks syscall
      pulse(1'b1, 1'b1, 1'b0);
      check("R3 interrupt wins over syscall", 32'(cur_bank), 32'd3);
      pulse(1'b0, 1'b0, 1'b1);
      check("R5 return after combined entry", 32'(cur_bank), 32'd0);

      // R6: event outranks software load
      set_bank(2'd1);
      sel_wr_en = 1'b1; sel_wr_val = 2'd0;
      pulse(1'b0, 1'b1, 1'b0);
      sel_wr_en = 1'b0;
      check("R6 syscall wins over software load", 32'(cur_bank), 32'd2);
      pulse(1'b0, 1'b0, 1'b1);
      check("R5 return to user bank 1", 32'(cur_bank), 32'd1);
      tick(); tick(); #1;
      check("R6 bank holds without inputs", 32'(cur_bank), 32'd1);

      // R7: register 0 ignores both write paths
      wr_en = 1'b1; wr_addr = 4'd0; wr_data = 32'hFFFF_FFFF;
      xm_wr_en = 1'b1; xm_bank = 2'd2; xm_addr = 4'd0; xm_wdata = 32'h1234_5678;
      rd_a_addr = 4'd0;
      #1;
      check("R7 reg0 no bypass", rd_a_data, 32'h0);
      tick();
      wr_en = 1'b0; xm_wr_en = 1'b0;
      #1;
      check("R7 reg0 after active write", rd_a_data, 32'h0);
      check("R7 reg0 after cross write", xm_rdata, 32'h0);

      // R11: independent same-cycle writes to different targets
      set_bank(2'd0);
      wr_en = 1'b1; wr_addr = 4'd9; wr_data = 32'h0000_0099;
      xm_wr_en = 1'b1; xm_bank = 2'd1; xm_addr = 4'd9; xm_wdata = 32'h0000_0019;
      tick();
      wr_en = 1'b0; xm_wr_en = 1'b0;
      rd_a_addr = 4'd9;
      #1;
      check("R11 cross write into other bank", xm_rdata, 32'h0000_0019);
      check("R2 active write beside cross write", rd_a_data, 32'h0000_0099);

      // R11: cross write may target the active bank
      xm_wr_en = 1'b1; xm_bank = 2'd0; xm_addr = 4'd11; xm_wdata = 32'h0000_0B0B;
      tick();
      xm_wr_en = 1'b0;
      rd_b_addr = 4'd11;
      #1;
      check("R11 cross write into active bank", rd_b_data, 32'h0000_0B0B);

      // R12: collision goes to the active-bank write
      wr_en = 1'b1; wr_addr = 4'd10; wr_data = 32'h0000_600D;
      xm_wr_en = 1'b1; xm_bank = 2'd0; xm_addr = 4'd10; xm_wdata = 32'h0000_0BAD;
      tick();
      wr_en = 1'b0; xm_wr_en = 1'b0;
      rd_a_addr = 4'd10;
      #1;
      check("R12 active write wins collision", rd_a_data, 32'h0000_600D);

      // R9: bypass on port B, port A on another address unaffected
      wr_en = 1'b1; wr_addr = 4'd1; wr_data = 32'h7777_7777;
      rd_b_addr = 4'd1; rd_a_addr = 4'd15;
      #1;
      check("R9 bypass on port B", rd_b_data, 32'h7777_7777);
      check("R9 other address not bypassed", rd_a_data, 32'hA5A5_A5A5);
      tick();
      wr_en = 1'b0;

      // R1: reset mid-run clears everything
      rst_n = 1'b0;
      #1;
      check("R1 bank on reset", 32'(cur_bank), 32'd2);
      xm_bank = 2'd0; xm_addr = 4'd15; #1;
      check("R1 contents cleared on reset", xm_rdata, 32'h0);
      tick();
      rst_n = 1'b1;
      tick();

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule